// File: doc/BRIEF.md
# Random-Complement Memory Self-Test Engine

This block is a built-in self-test controller for a word-addressed synchronous memory with single-cycle read latency. Once triggered, it walks an address window four times. On the first walk it writes a pseudo-random word to every location. On the second it writes the bitwise inverse of the same words. On the third it reads each location, checks it against the inverse and writes the original word back. On the fourth it reads each location and checks it against the original word.

The random words are not stored anywhere. A 64-bit xorshift generator is reloaded from a persistent seed register at the start of every walk, so each walk regenerates the same sequence. Every compare that fails produces a one-cycle error record carrying the address, the expected word, the word that was read and their XOR.

At the end, a one-cycle done pulse is raised together with a pass/fail result. The seed register advances to the generator's final state only when the run passed. A stop request is honoured only in the idle cycle between two walks, and it ends the run as a failure.

Top module: `randcomp_mbist`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `busy`, `done`, `pass`, `mem_we`, `mem_re` and `err_valid` are all 0.
- R2: The generator maps x to t with three steps in order: t = x ^ (x << 13); t ^= t >> 7; t ^= t << 17. The seed register resets to 64'h9E3779B97F4A7C15. The word used for the k-th location of a walk (k counted from 0) is the seed advanced k times.
- R3: After a start pulse in idle, `mem_we` is 1 in each of the next N cycles, where N = end − start. The write addresses run upward from `start_addr` to `end_addr`−1, and each location receives its word. Writes never leave the window.
- R4: After one idle bus cycle, the second walk writes the bitwise inverse of the same word sequence, one location per cycle, upward.
- R5: After another idle cycle, the third walk spends three cycles on each location: a read cycle, then a compare cycle with no bus access, then a write cycle that restores the original word. The compare is against the inverse.
- R6: After another idle cycle, the fourth walk spends two cycles on each location: a read cycle, then a compare cycle in which the returned data is checked against the original word.
- R7: In a compare cycle whose data differs, `err_valid` is 1. In that cycle `err_addr` is the location, `err_exp` is the expected word, `err_act` is the data read and `err_diff` is their XOR. `err_valid` is 0 in every other cycle.
- R8: One bus-idle cycle follows the last compare. In the cycle after it, `busy` is 0 and `done` is 1 for exactly one cycle. `pass` is 1 only if no compare failed, and it holds that value until the next start.
- R9: The seed register takes the generator's final state only at the end of a passing run. After a failing run, the next run regenerates the same words.
- R10: `stop` is sampled only in the idle cycle between two walks. If it is 1 there, no further memory access occurs, `done` pulses in the next cycle and `pass` is 0.
- R11: If `end_addr` is not greater than `start_addr`, the run makes no memory access, stays busy for one cycle, passes, and leaves the seed unchanged.
- R12: `start` has no effect while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| stop | input | 1 | Abort request, honoured between walks |
| start_addr | input | AW | First location of the window |
| end_addr | input | AW | One past the last location of the window |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Result of the last run |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 64 | Memory write data |
| mem_rdata | input | 64 | Memory read data, valid the cycle after `mem_re` |
| err_valid | output | 1 | Error record strobe |
| err_addr | output | AW | Failing location |
| err_exp | output | 64 | Expected word |
| err_act | output | 64 | Word read |
| err_diff | output | 64 | XOR of expected and read words |

## Verification
The assertions assume the following about the block's inputs:
- The memory returns read data exactly one cycle after `mem_re`.
- `start_addr` and `end_addr` matter only on the cycle `start` is taken, because the engine latches them then.
- The seed reset value is not zero.

The bench drives the window only at start time and models a memory with a fixed one-cycle read register. It changes its stuck-at fault only while the engine is idle. It raises `stop` only in the cycle the model predicts to be a gap between walks.

// File: rtl/rcmt_pkg.sv
// Package: shared types and the generator step for the random-complement
// memory self-test. Assumes a 64-bit data word.
package rcmt_pkg;

    localparam int WORD_W = 64;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FILL,   // walk 1: write random words
        ST_INV,    // walk 2: write inverted words
        ST_RD3,    // walk 3: issue read
        ST_CMP3,   // walk 3: compare against inverse
        ST_WB3,    // walk 3: restore original
        ST_RD4,    // walk 4: issue read
        ST_CMP4,   // walk 4: compare against original
        ST_GAP,    // idle cycle between walks, stop sampled
        ST_FIN     // closing cycle, result formed
    } state_e;

    // One xorshift step; maximal length over non-zero 64-bit states.
    function automatic logic [WORD_W-1:0] xs_next(input logic [WORD_W-1:0] x);
        logic [WORD_W-1:0] t;
        t = x ^ (x << 13);
        t = t ^ (t >> 7);
        t = t ^ (t << 17);
        return t;
    endfunction

endpackage

// File: rtl/rcmt_prng.sv
// Module: pseudo-random word source. Holds the generator state, reloads it
// from a seed on request and advances it one step per accessed location.
// Assumes the seed presented on load is non-zero.
module rcmt_prng
    import rcmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [WORD_W-1:0] seed,
    output logic [WORD_W-1:0] word
);

    localparam logic [WORD_W-1:0] RESET_STATE = {{(WORD_W-1){1'b0}}, 1'b1};

    logic [WORD_W-1:0] state_q;

    // State register: reload wins over step.
    always_ff @(posedge clk) begin
        if (!rst_n)       state_q <= RESET_STATE;
        else if (load)    state_q <= seed;
        else if (step)    state_q <= xs_next(state_q);
    end

    assign word = state_q;

    assert_state_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

endmodule

// File: rtl/rcmt_seed_store.sv
// Module: persistent seed register. Takes the generator's final state when
// the controller commits a passing run, otherwise holds.
module rcmt_seed_store
    import rcmt_pkg::*;
#(
    parameter logic [WORD_W-1:0] SEED_INIT = 64'h9E3779B97F4A7C15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [WORD_W-1:0] final_state,
    output logic [WORD_W-1:0] seed
);

    logic [WORD_W-1:0] seed_q;

    // Seed register: updates only on commit.
    always_ff @(posedge clk) begin
        if (!rst_n)      seed_q <= SEED_INIT;
        else if (commit) seed_q <= final_state;
    end

    assign seed = seed_q;

    assert_seed_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(seed_q) |-> $past(commit));

endmodule

// File: rtl/rcmt_ctrl.sv
// Module: walk sequencer. Steps through the four walks over the latched
// window, drives the memory port, compares returned data and forms the
// result. Assumes read data arrives exactly one cycle after mem_re.
module rcmt_ctrl
    import rcmt_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic [AW-1:0]     start_addr,
    input  logic [AW-1:0]     end_addr,
    input  logic [WORD_W-1:0] word,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              prng_load,
    output logic              prng_step,
    output logic              commit,
    output logic              mem_we,
    output logic              mem_re,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              err_valid,
    output logic [AW-1:0]     err_addr,
    output logic [WORD_W-1:0] err_exp,
    output logic [WORD_W-1:0] err_act,
    output logic [WORD_W-1:0] err_diff
);

    state_e            state_q, resume_q;
    logic [AW-1:0]     addr_q, lo_q, hi_q;
    logic              err_flag_q, done_q, pass_q;
    logic              last_loc, cmp_active, mismatch;
    logic [WORD_W-1:0] cmp_exp;

    // Bus and compare decode from the current state.
    always_comb begin
        mem_we     = (state_q == ST_FILL) || (state_q == ST_INV) || (state_q == ST_WB3);
        mem_re     = (state_q == ST_RD3) || (state_q == ST_RD4);
        mem_addr   = addr_q;
        mem_wdata  = (state_q == ST_INV) ? ~word : word;
        cmp_active = (state_q == ST_CMP3) || (state_q == ST_CMP4);
        cmp_exp    = (state_q == ST_CMP3) ? ~word : word;
        mismatch   = cmp_active && (mem_rdata != cmp_exp);
        last_loc   = (addr_q == hi_q - 1'b1);
    end

    // Generator and seed control.
    always_comb begin
        prng_load = ((state_q == ST_IDLE) && start) || ((state_q == ST_GAP) && !stop);
        prng_step = (state_q == ST_FILL) || (state_q == ST_INV) ||
                    (state_q == ST_WB3)  || (state_q == ST_CMP4);
        commit    = (state_q == ST_FIN) && !err_flag_q;
    end

    // Error record, valid in a failing compare cycle.
    always_comb begin
        err_valid = mismatch;
        err_addr  = addr_q;
        err_exp   = cmp_exp;
        err_act   = mem_rdata;
        err_diff  = cmp_exp ^ mem_rdata;
    end

    // Sequencer: state, address walk, sticky error and result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            resume_q   <= ST_IDLE;
            addr_q     <= '0;
            lo_q       <= '0;
            hi_q       <= '0;
            err_flag_q <= 1'b0;
            done_q     <= 1'b0;
            pass_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        lo_q       <= start_addr;
                        hi_q       <= end_addr;
                        addr_q     <= start_addr;
                        err_flag_q <= 1'b0;
                        pass_q     <= 1'b0;
                        state_q    <= (end_addr > start_addr) ? ST_FILL : ST_FIN;
                    end
                end
                ST_FILL, ST_INV: begin
                    if (last_loc) begin
                        addr_q   <= lo_q;
                        resume_q <= (state_q == ST_FILL) ? ST_INV : ST_RD3;
                        state_q  <= ST_GAP;
                    end else begin
                        addr_q <= addr_q + 1'b1;
                    end
                end
                ST_GAP: begin
                    if (stop) begin
                        done_q  <= 1'b1;
                        pass_q  <= 1'b0;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= resume_q;
                    end
                end
                ST_RD3: state_q <= ST_CMP3;
                ST_CMP3: begin
                    if (mismatch) err_flag_q <= 1'b1;
                    state_q <= ST_WB3;
                end
                ST_WB3: begin
                    if (last_loc) begin
                        addr_q   <= lo_q;
                        resume_q <= ST_RD4;
                        state_q  <= ST_GAP;
                    end else begin
                        addr_q  <= addr_q + 1'b1;
                        state_q <= ST_RD3;
                    end
                end
                ST_RD4: state_q <= ST_CMP4;
                ST_CMP4: begin
                    if (mismatch) err_flag_q <= 1'b1;
                    if (last_loc) begin
                        state_q <= ST_FIN;
                    end else begin
                        addr_q  <= addr_q + 1'b1;
                        state_q <= ST_RD4;
                    end
                end
                ST_FIN: begin
                    done_q  <= 1'b1;
                    pass_q  <= !err_flag_q;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign done = done_q;
    assign pass = pass_q;

    assert_write_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr >= lo_q) && (mem_addr < hi_q));

    assert_done_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_fall_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_err_only_compare_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> busy && !mem_we && !mem_re);

    assert_stop_aborts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) && stop |=> done && !pass && !busy);

endmodule

// File: rtl/randcomp_mbist.sv
// Module: top of the random-complement memory self-test. Connects the walk
// sequencer, the random word source and the persistent seed store.
// Assumes a memory with one-cycle read latency on the attached port.
module randcomp_mbist
    import rcmt_pkg::*;
#(
    parameter int                AW        = 6,
    parameter logic [WORD_W-1:0] SEED_INIT = 64'h9E3779B97F4A7C15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic [AW-1:0]     start_addr,
    input  logic [AW-1:0]     end_addr,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              mem_we,
    output logic              mem_re,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              err_valid,
    output logic [AW-1:0]     err_addr,
    output logic [WORD_W-1:0] err_exp,
    output logic [WORD_W-1:0] err_act,
    output logic [WORD_W-1:0] err_diff
);

    logic              prng_load, prng_step, commit;
    logic [WORD_W-1:0] word, seed;

    rcmt_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .start_addr(start_addr), .end_addr(end_addr),
        .word(word), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .pass(pass),
        .prng_load(prng_load), .prng_step(prng_step), .commit(commit),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .err_valid(err_valid), .err_addr(err_addr), .err_exp(err_exp),
        .err_act(err_act), .err_diff(err_diff)
    );

    rcmt_prng u_prng (
        .clk(clk), .rst_n(rst_n), .load(prng_load), .step(prng_step),
        .seed(seed), .word(word)
    );

    rcmt_seed_store #(.SEED_INIT(SEED_INIT)) u_seed (
        .clk(clk), .rst_n(rst_n), .commit(commit),
        .final_state(word), .seed(seed)
    );

endmodule

// File: tb/randcomp_mbist_tb.sv
module randcomp_mbist_tb;

    localparam int AW = 6;
    localparam logic [63:0] SEED0 = 64'h9E3779B97F4A7C15;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n, start, stop;
    logic [AW-1:0] start_addr, end_addr;
    logic          busy, done, pass, mem_we, mem_re, err_valid;
    logic [AW-1:0] mem_addr, err_addr;
    logic [63:0]   mem_wdata, mem_rdata, err_exp, err_act, err_diff;

    randcomp_mbist #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .start_addr(start_addr), .end_addr(end_addr),
        .busy(busy), .done(done), .pass(pass),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .err_valid(err_valid), .err_addr(err_addr),
        .err_exp(err_exp), .err_act(err_act), .err_diff(err_diff)
    );

    // Behavioural memory with one stuck-at-1 fault site.
    logic [63:0]   mem [64];
    logic [AW-1:0] flt_addr;
    logic [63:0]   flt_mask;
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr] | ((mem_addr == flt_addr) ? flt_mask : 64'd0);
    end

    int n_chk = 0;
    int n_err = 0;

    typedef struct packed {
        logic          we;
        logic          re;
        logic [AW-1:0] addr;
        logic [63:0]   wd;
        logic          ev;
        logic [63:0]   eexp;
        logic [63:0]   eact;
        logic [1:0]    gap;
    } ent_t;

    ent_t  q[$];
    string tq[$];
    logic [63:0] seed_m = SEED0;

    // R2: generator step.
    function automatic logic [63:0] nx(input logic [63:0] x);
        logic [63:0] t;
        t = x ^ (x << 13);
        t = t ^ (t >> 7);
        t = t ^ (t << 17);
        return t;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic we, input logic re, input int a, input logic [63:0] wd,
                        input logic ev, input logic [63:0] ee, input logic [63:0] ea,
                        input int gap, input string tag);
        ent_t e;
        e.we = we; e.re = re; e.addr = AW'(a); e.wd = wd;
        e.ev = ev; e.eexp = ee; e.eact = ea; e.gap = 2'(gap);
        q.push_back(e);
        tq.push_back(tag);
    endtask

    // Reference: expected cycle-by-cycle bus and error trace of one run.
    task automatic build(input int lo, input int hi, input int stop_at, input int fa,
                         input logic [63:0] fm, output bit ep);
        logic [63:0] x, act;
        bit bad;
        bad = 0;
        x = seed_m;
        q.delete();
        tq.delete();
        if (hi > lo) begin
            for (int a = lo; a < hi; a++) begin push(1, 0, a, x, 0, 0, 0, 0, "R3"); x = nx(x); end
            push(0, 0, 0, 0, 0, 0, 0, 1, "R10");
            if (stop_at == 1) begin ep = 0; return; end
            x = seed_m;
            for (int a = lo; a < hi; a++) begin push(1, 0, a, ~x, 0, 0, 0, 0, "R4"); x = nx(x); end
            push(0, 0, 0, 0, 0, 0, 0, 2, "R10");
            if (stop_at == 2) begin ep = 0; return; end
            x = seed_m;
            for (int a = lo; a < hi; a++) begin
                act = ~x | ((a == fa) ? fm : 64'd0);
                push(0, 1, a, 0, 0, 0, 0, 0, "R5");
                push(0, 0, a, 0, act != ~x, ~x, act, 0, "R5");
                bad |= (act != ~x);
                push(1, 0, a, x, 0, 0, 0, 0, "R5");
                x = nx(x);
            end
            push(0, 0, 0, 0, 0, 0, 0, 3, "R10");
            if (stop_at == 3) begin ep = 0; return; end
            x = seed_m;
            for (int a = lo; a < hi; a++) begin
                act = x | ((a == fa) ? fm : 64'd0);
                push(0, 1, a, 0, 0, 0, 0, 0, "R6");
                push(0, 0, a, 0, act != x, x, act, 0, "R6");
                bad |= (act != x);
                x = nx(x);
            end
        end
        push(0, 0, 0, 0, 0, 0, 0, 0, (hi > lo) ? "R8" : "R11");
        ep = !bad;
        if (ep) seed_m = x;
    endtask

    // Runs one test and compares every cycle against the reference trace.
    task automatic run(input int lo, input int hi, input int stop_at, input int fa,
                       input logic [63:0] fm, input bit poke);
        bit   ep;
        ent_t e;
        string t;
        int   idx;
        idx = 0;
        flt_addr = AW'(fa);
        flt_mask = fm;
        build(lo, hi, stop_at, fa, fm, ep);
        start_addr = AW'(lo);
        end_addr = AW'(hi);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (q.size() > 0) begin
            e = q.pop_front();
            t = tq.pop_front();
            chk(busy === 1'b1, t, "busy", 64'(busy), 1);
            chk(mem_we === e.we && mem_re === e.re, t, "we/re",
                64'({mem_we, mem_re}), 64'({e.we, e.re}));
            if (e.we || e.re) chk(mem_addr === e.addr, t, "addr", 64'(mem_addr), 64'(e.addr));
            if (e.we) chk(mem_wdata === e.wd, t, "wdata", mem_wdata, e.wd);
            chk(err_valid === e.ev, "R7", "err_valid", 64'(err_valid), 64'(e.ev));
            if (e.ev) begin
                chk(err_addr === e.addr, "R7", "err_addr", 64'(err_addr), 64'(e.addr));
                chk(err_exp === e.eexp, "R7", "err_exp", err_exp, e.eexp);
                chk(err_act === e.eact, "R7", "err_act", err_act, e.eact);
                chk(err_diff === (e.eexp ^ e.eact), "R7", "err_diff", err_diff, e.eexp ^ e.eact);
            end
            start = (poke && idx == 5);   // R12: start while busy must be ignored
            if (e.gap != 0 && int'(e.gap) == stop_at) stop = 1'b1;
            idx++;
            @(negedge clk);
            start = 1'b0;
            stop = 1'b0;
        end
        chk(done === 1'b1 && busy === 1'b0, "R8", "done/busy at end",
            64'({done, busy}), 64'b10);
        chk(pass === ep, (stop_at != 0) ? "R10" : "R8", "pass", 64'(pass), 64'(ep));
        @(negedge clk);
        chk(done === 1'b0, "R8", "done pulse width", 64'(done), 0);
        chk(pass === ep, "R8", "pass held", 64'(pass), 64'(ep));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; stop = 1'b0;
        start_addr = '0; end_addr = '0; flt_addr = '0; flt_mask = '0;
        repeat (3) @(negedge clk);
        chk({busy, done, pass, mem_we, mem_re, err_valid} === 6'b0, "R1", "outputs in reset",
            64'({busy, done, pass, mem_we, mem_re, err_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, pass, mem_we, mem_re, err_valid} === 6'b0, "R1", "outputs after reset",
            64'({busy, done, pass, mem_we, mem_re, err_valid}), 0);

        run(4, 12, 0, 0, 64'd0, 0);            // R2 R3 R4 R5 R6: clean pass from reset seed
        run(0, 63, 0, 0, 64'd0, 1);            // R9 advanced seed, R12 start poke, full window
        run(2, 9, 0, 5, 64'h1, 0);             // R7 stuck bit 0 at location 5, fail
        run(2, 9, 0, 0, 64'd0, 0);             // R9 same words after a failed run
        run(10, 20, 0, 13, 64'hF000_0000_0000_0000, 0); // R7 upper-bit fault
        run(10, 20, 1, 0, 64'd0, 0);           // R10 stop after walk 1
        run(10, 20, 3, 0, 64'd0, 0);           // R10 stop after walk 3
        run(30, 30, 0, 0, 64'd0, 0);           // R11 equal bounds
        run(40, 8, 0, 0, 64'd0, 0);            // R11 end below start
        run(7, 8, 0, 0, 64'd0, 0);             // single location
        run(5, 25, 2, 0, 64'd0, 0);            // R10 stop after walk 2
        run(5, 25, 0, 0, 64'd0, 0);            // clean pass after abort

        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule